// File: doc/BRIEF.md
# Debug Breakpoint and Trace Trigger Controller

This block decides what happens once an on-chip debug unit fires its trigger. Three events can fire it while the unit is armed: the comparator sequencer entering its final state, a tagged opcode arriving at the execute stage, or software writing a trigger bit. Based on four configuration bits, the controller then does one of three things. It can request a CPU breakpoint at once. It can start a trace and defer the breakpoint until that trace completes. Or it can stop a trace that was already filling and disarm.

Software arms the unit with a one-cycle arm pulse. A breakpoint request is a level that stays high until the CPU acknowledges it, after which the unit returns to the disarmed state. Three pieces sit outside this block and connect to it through the ports: the trace memory, the comparators and the CPU.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset, `ctrl_state` is 0 (disarmed), and `trace_start`, `trace_stop` and `brk_req` are low.
- R2: The `ctrl_state` encoding is 0 disarmed, 1 armed, 2 tracing, 3 break pending. When disarmed, an `arm_set` pulse moves the state to 1 on the next clock. When disarmed, all trigger inputs, `trace_done` and `cpu_ack` have no effect on any output.
- R3: With `cfg_trace_en` low, a trigger while armed raises `brk_req` on the next clock if `cfg_brk_en` is high. If `cfg_brk_en` is low, the state returns to 0 and no breakpoint is raised.
- R4: With `cfg_trace_en` and `cfg_end_align` both high, arming produces a one-cycle `trace_start` pulse. A later trigger produces a one-cycle `trace_stop` pulse. In the same cycle the state goes to 3 if `cfg_brk_en` is high, otherwise to 0.
- R5: With `cfg_trace_en` high and `cfg_end_align` low, a trigger produces a one-cycle `trace_start` pulse. If `cfg_brk_now` and `cfg_brk_en` are not both high, the state goes to 2 and `brk_req` stays low until `trace_done`. On `trace_done` the state goes to 3 if `cfg_brk_en` is high, otherwise to 0.
- R6: With `cfg_trace_en`, `cfg_brk_en` and `cfg_brk_now` high and `cfg_end_align` low, a trigger produces `trace_start` and `brk_req` on the same clock, without waiting for `trace_done`.
- R7: `brk_req` stays high for as long as `cpu_ack` is low. The clock after `cpu_ack` is seen, the state is 0 and `brk_req` is low.
- R8: `final_hit`, `tag_exec` and `sw_trig` act as identical triggers while armed.
- R9: `trace_done` has no effect while the state is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set | input | 1 | Software arm pulse |
| final_hit | input | 1 | Sequencer entered final state (untagged match) |
| tag_exec | input | 1 | Tagged opcode reached execute stage |
| sw_trig | input | 1 | Software trigger write |
| trace_done | input | 1 | Trace buffer reports session complete |
| cpu_ack | input | 1 | CPU acknowledges breakpoint |
| cfg_trace_en | input | 1 | Tracing selected |
| cfg_end_align | input | 1 | 1 = end alignment, 0 = begin alignment |
| cfg_brk_en | input | 1 | Breakpoints enabled |
| cfg_brk_now | input | 1 | Break immediately regardless of alignment |
| ctrl_state | output | 2 | Controller state (encoding in R2) |
| trace_start | output | 1 | One-cycle trace start pulse |
| trace_stop | output | 1 | One-cycle trace stop/disarm pulse |
| brk_req | output | 1 | Breakpoint request level |

## Verification
The block has no parameters, so the bench builds its single configuration. This lets a vector table cover the combinations of the four configuration bits that lead to different outcomes, and it rotates through all three trigger sources across the table. Directed tests follow the table. They target inputs that arrive in the wrong state, such as a trace completion while armed or events while disarmed, and a breakpoint request held for several cycles without an acknowledge.

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_set,
  input  logic       final_hit,
  input  logic       tag_exec,
  input  logic       sw_trig,
  input  logic       trace_done,
  input  logic       cpu_ack,
  input  logic       cfg_trace_en,
  input  logic       cfg_end_align,
  input  logic       cfg_brk_en,
  input  logic       cfg_brk_now,
  output logic [1:0] ctrl_state,
  output logic       trace_start,
  output logic       trace_stop,
  output logic       brk_req
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ARM  = 2'd1;
  localparam logic [1:0] S_TRC  = 2'd2;
  localparam logic [1:0] S_BRK  = 2'd3;

  logic [1:0] st, nxt;
  logic       start_n, stop_n;
  logic       trig;
  logic [1:0] brk_or_idle;

  assign trig        = final_hit | tag_exec | sw_trig;
  assign brk_or_idle = cfg_brk_en ? S_BRK : S_IDLE;

  always_comb begin
    nxt     = st;
    start_n = 1'b0;
    stop_n  = 1'b0;
    case (st)
      S_IDLE: if (arm_set) begin
        nxt     = S_ARM;
        start_n = cfg_trace_en & cfg_end_align;
      end
      S_ARM: if (trig) begin
        if (!cfg_trace_en) begin
          nxt = brk_or_idle;
        end else if (cfg_end_align) begin
          stop_n = 1'b1;
          nxt    = brk_or_idle;
        end else begin
          start_n = 1'b1;
          nxt     = (cfg_brk_en && cfg_brk_now) ? S_BRK : S_TRC;
        end
      end
      S_TRC: if (trace_done) nxt = brk_or_idle;
      S_BRK: if (cpu_ack) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      trace_start <= 1'b0;
      trace_stop  <= 1'b0;
    end else begin
      st          <= nxt;
      trace_start <= start_n;
      trace_stop  <= stop_n;
    end
  end

  assign ctrl_state = st;
  assign brk_req    = (st == S_BRK);
endmodule

// File: rtl/dbg_brk_ctrl_chk.sv
module dbg_brk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_set,
  input logic       final_hit,
  input logic       tag_exec,
  input logic       sw_trig,
  input logic       trace_done,
  input logic       cpu_ack,
  input logic       cfg_trace_en,
  input logic       cfg_end_align,
  input logic       cfg_brk_en,
  input logic       cfg_brk_now,
  input logic [1:0] ctrl_state,
  input logic       trace_start,
  input logic       trace_stop,
  input logic       brk_req
);
  logic trig;
  assign trig = final_hit | tag_exec | sw_trig;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == 2'd0 && !arm_set) |=> (ctrl_state == 2'd0 && !brk_req && !trace_start));

  assert_direct_brk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == 2'd1 && trig && !cfg_trace_en && cfg_brk_en) |=> brk_req);

  assert_stop_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_stop |=> !trace_stop);

  assert_defer_brk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == 2'd1 && trig && cfg_trace_en && !cfg_end_align && !(cfg_brk_en && cfg_brk_now))
    |=> (!brk_req && trace_start && ctrl_state == 2'd2));

  assert_brk_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !cpu_ack) |=> brk_req);

  assert_brk_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && cpu_ack) |=> (ctrl_state == 2'd0 && !brk_req));

  assert_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == 2'd1 && !trig) |=> (ctrl_state == 2'd1));
endmodule

bind dbg_brk_ctrl dbg_brk_ctrl_chk u_chk (.*);

// File: tb/tb_dbg_brk_ctrl.sv
module tb_dbg_brk_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_set = 0, final_hit = 0, tag_exec = 0, sw_trig = 0, trace_done = 0, cpu_ack = 0;
  logic cfg_trace_en = 0, cfg_end_align = 0, cfg_brk_en = 0, cfg_brk_now = 0;
  logic [1:0] ctrl_state;
  logic trace_start, trace_stop, brk_req;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dbg_brk_ctrl dut (.*);

  // {te, ea, be, bn, src[1:0], exp_start, exp_stop, exp_state[1:0], exp_after_done[1:0]}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0010, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0},  // R3
    {4'b0000, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0},  // R3
    {4'b0111, 2'd2, 1'b0, 1'b0, 2'd3, 2'd0},  // R3
    {4'b1110, 2'd0, 1'b0, 1'b1, 2'd3, 2'd0},  // R4
    {4'b1100, 2'd1, 1'b0, 1'b1, 2'd0, 2'd0},  // R4
    {4'b1010, 2'd2, 1'b1, 1'b0, 2'd2, 2'd3},  // R5
    {4'b1000, 2'd0, 1'b1, 1'b0, 2'd2, 2'd0},  // R5
    {4'b1011, 2'd1, 1'b1, 1'b0, 2'd3, 2'd0},  // R6
    {4'b1001, 2'd2, 1'b1, 1'b0, 2'd2, 2'd0},  // R5
    {4'b1111, 2'd1, 1'b0, 1'b1, 2'd3, 2'd0}   // R4
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_pulses();
    arm_set = 0; final_hit = 0; tag_exec = 0; sw_trig = 0; trace_done = 0; cpu_ack = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) tick();
    chk("R1 state", ctrl_state, 0);
    chk("R1 outputs", {trace_start, trace_stop, brk_req}, 0);
    rst_n = 1'b1;
    tick();

    // R2: events while disarmed are ignored
    cfg_trace_en = 1; cfg_brk_en = 1; cfg_brk_now = 1;
    final_hit = 1; tag_exec = 1; sw_trig = 1; trace_done = 1; cpu_ack = 1;
    tick(); clear_pulses();
    chk("R2 idle state", ctrl_state, 0);
    chk("R2 idle outputs", {trace_start, trace_stop, brk_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      {cfg_trace_en, cfg_end_align, cfg_brk_en, cfg_brk_now} = v[11:8];
      arm_set = 1;
      tick(); clear_pulses();
      chk("R2 armed", ctrl_state, 1);
      chk("R4 start on arm", trace_start, int'(v[11] & v[10]));
      tick();
      chk("R4 start pulse ends", trace_start, 0);
      // R8: rotate trigger source
      case (v[7:6])
        2'd0: final_hit = 1;
        2'd1: tag_exec = 1;
        default: sw_trig = 1;
      endcase
      tick(); clear_pulses();
      chk("R3/R4/R5/R6/R8 start", trace_start, int'(v[5]));
      chk("R4 stop", trace_stop, int'(v[4]));
      chk("R3/R4/R5/R6/R8 state", ctrl_state, int'(v[3:2]));
      chk("R3/R6 brk", brk_req, int'(v[3:2] == 2'd3));
      if (v[3:2] == 2'd2) begin
        tick(); tick();
        chk("R5 no brk while tracing", brk_req, 0);
        trace_done = 1;
        tick(); clear_pulses();
        chk("R5 after done", ctrl_state, int'(v[1:0]));
      end
      tick();
      chk("R4 stop pulse ends", trace_stop, 0);
      if (ctrl_state == 2'd3) begin
        cpu_ack = 1;
        tick(); clear_pulses();
        chk("R7 release", {ctrl_state, brk_req}, 0);
      end
    end

    // R9: trace_done ignored when armed; R7: held without ack
    {cfg_trace_en, cfg_end_align, cfg_brk_en, cfg_brk_now} = 4'b0010;
    arm_set = 1; tick(); clear_pulses();
    trace_done = 1; tick(); clear_pulses();
    chk("R9 done ignored", ctrl_state, 1);
    chk("R9 no brk", brk_req, 0);
    sw_trig = 1; tick(); clear_pulses();
    repeat (5) tick();
    chk("R7 held", brk_req, 1);
    cpu_ack = 1; tick(); clear_pulses();
    chk("R7 cleared", {ctrl_state, brk_req}, 0);

    // R1: reset mid-session
    arm_set = 1; tick(); clear_pulses();
    rst_n = 0; tick();
    chk("R1 reset again", ctrl_state, 0);
    rst_n = 1; tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule